// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a 16-bit differential successive-approximation converter. A rising edge on the convert input latches the analog sample (outside this block) and starts a binary search. The search runs one bit per clock, most significant bit first. On each step the block presents a trial word to the capacitive switch bank and, one clock later, reads a single comparator decision. After the last bit it delivers a signed result together with a one-cycle strobe.

The trial word is offset binary: code 0 is the most negative input and all ones is the most positive. The delivered result is the same code turned into two's complement. Two timing rules mark a result as untrustworthy through an invalid qualifier that goes out with the strobe. The first rule covers the first conversion after reset. The second covers a conversion that follows an idle gap longer than a parameterised number of clock cycles, which stands in for the converter's maximum time between conversions.

Top module: `sar_seq`

## Requirements
- R1: A conversion starts on the first clock edge at which `conv_i` is sampled high after being sampled low, provided no conversion is running. From the next cycle `busy_o` is high and `trial_o` equals 0x8000, which is only the MSB set.
- R2: On each busy cycle the block samples `cmp_i` at the clock edge that ends the cycle in which the current trial word was applied. The bit under test is kept when `cmp_i` is 1, meaning the DAC value is at or below the input, and cleared when `cmp_i` is 0. The next lower bit is then set in the following trial word, so the search goes from MSB to LSB.
- R3: `valid_o` is high for exactly one cycle: the cycle that follows the 16th clock edge after the start edge. In that cycle `busy_o` is low.
- R4: `result_o` is the final offset-binary code with its MSB inverted, in two's complement. An input at the bottom of the range gives 0x8000, one at the top gives 0x7FFF, and midscale gives 0x0000.
- R5: Convert edges that arrive while a conversion is busy are ignored. The running conversion completes with one result, and the idle gap is still measured from the accepted start.
- R6: The first result after reset has `invalid_o` high.
- R7: Let the gap between two accepted start edges be counted in clock cycles. If that gap exceeds `IDLE_LIMIT`, the later result has `invalid_o` high. A gap of exactly `IDLE_LIMIT` leaves it low.
- R8: A synchronous active-high `rst` aborts any conversion without producing a result. It clears `busy_o`, `valid_o` and `trial_o`, and re-arms R6.
- R9: Holding `conv_i` high past the end of a conversion does not start another one. A new start needs `conv_i` to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_i | input | 1 | Convert request; its rising edge starts a conversion |
| cmp_i | input | 1 | Comparator decision: 1 when the DAC trial value is at or below the sampled input |
| trial_o | output | W | Offset-binary trial word for the switch bank; zero while idle |
| busy_o | output | 1 | High while the bit search runs |
| result_o | output | W | Two's-complement conversion result, held until the next result |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| invalid_o | output | 1 | Qualifier sent with `valid_o`: the result breaks the first-result or idle-gap rule |

## Verification
The bench builds the block with W = 16 and IDLE_LIMIT = 40. Those values are close enough to the 17-cycle conversion time that gaps of 40 and 41 cycles, the two sides of the idle boundary, fit in a few back-to-back conversions. The full 16-bit search is still exercised against an ideal comparator on both full-scale codes, midscale, and mixed bit patterns. Retrigger, held-high and mid-conversion reset cases then show that the qualifier tracks only accepted starts.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_TEST = 1'b1
    } sar_state_e;

endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
        rise_o = level_i && !prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end

endmodule

// File: rtl/sar_idle_timer.sv
module sar_idle_timer #(
    parameter int IDLE_LIMIT = 600
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    output logic stale_o
);

    localparam int CW = $clog2(IDLE_LIMIT + 2);
    localparam logic [CW-1:0] LIM_C = CW'(IDLE_LIMIT);
    localparam logic [CW-1:0] SAT_C = CW'(IDLE_LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    // cnt_q equals the number of edges since the last accepted start,
    // saturating one beyond the limit.
    always_comb begin
        stale_o = (cnt_q > LIM_C);
        if (restart_i)          cnt_d = CW'(1);
        else if (cnt_q < SAT_C) cnt_d = cnt_q + CW'(1);
        else                    cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

endmodule

// File: rtl/sar_core.sv
module sar_core
    import sar_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         stale_i,
    input  logic         cmp_i,
    output logic         accept_o,
    output logic [W-1:0] trial_o,
    output logic         busy_o,
    output logic [W-1:0] result_o,
    output logic         valid_o,
    output logic         invalid_o
);

    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        sar_state_e   state;
        logic [W-1:0] trial;
        logic [W-1:0] bitsel;
        logic [W-1:0] result;
        logic         valid;
        logic         invalid;
        logic         bad_pend;
        logic         first;
    } core_t;

    core_t r_d, r_q;
    logic [W-1:0] kept_code;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        accept_o  = 1'b0;
        kept_code = cmp_i ? r_q.trial : (r_q.trial & ~r_q.bitsel);

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    accept_o     = 1'b1;
                    r_d.state    = ST_TEST;
                    r_d.trial    = TOP_BIT;
                    r_d.bitsel   = TOP_BIT;
                    r_d.bad_pend = r_q.first || stale_i;
                    r_d.first    = 1'b0;
                end
            end
            ST_TEST: begin
                if (r_q.bitsel[0]) begin
                    r_d.state   = ST_IDLE;
                    r_d.trial   = '0;
                    r_d.bitsel  = '0;
                    r_d.result  = kept_code ^ TOP_BIT;
                    r_d.valid   = 1'b1;
                    r_d.invalid = r_q.bad_pend;
                end else begin
                    r_d.trial  = kept_code | (r_q.bitsel >> 1);
                    r_d.bitsel = r_q.bitsel >> 1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q          <= '0;
            r_q.state    <= ST_IDLE;
            r_q.first    <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign trial_o   = r_q.trial;
    assign busy_o    = (r_q.state == ST_TEST);
    assign result_o  = r_q.result;
    assign valid_o   = r_q.valid;
    assign invalid_o = r_q.invalid;

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
    parameter int W          = 16,
    parameter int IDLE_LIMIT = 600
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         conv_i,
    input  logic         cmp_i,
    output logic [W-1:0] trial_o,
    output logic         busy_o,
    output logic [W-1:0] result_o,
    output logic         valid_o,
    output logic         invalid_o
);

    logic conv_rise;
    logic accepted;
    logic stale;

    sar_edge_det u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (conv_i),
        .rise_o  (conv_rise)
    );

    sar_idle_timer #(.IDLE_LIMIT(IDLE_LIMIT)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart_i (accepted),
        .stale_o   (stale)
    );

    sar_core #(.W(W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .start_i   (conv_rise),
        .stale_i   (stale),
        .cmp_i     (cmp_i),
        .accept_o  (accepted),
        .trial_o   (trial_o),
        .busy_o    (busy_o),
        .result_o  (result_o),
        .valid_o   (valid_o),
        .invalid_o (invalid_o)
    );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] trial_o,
    input logic         busy_o,
    input logic         valid_o,
    input logic         invalid_o
);

    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    logic seen_q;
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst)          seen_q <= 1'b0;
        else if (valid_o) seen_q <= 1'b1;
    end

    assert_first_trial_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (trial_o == TOP_BIT));

    assert_trial_live_R2: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (trial_o != '0));

    assert_strobe_end_R3: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (!busy_o && $past(busy_o)));

    assert_strobe_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    assert_first_invalid_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !seen_q) |-> invalid_o);

    always_ff @(posedge clk) begin
        if (rst_q) begin
            assert_reset_idle_R8: assert (!busy_o && !valid_o && trial_o == '0);
        end
    end

endmodule

bind sar_seq sar_seq_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .trial_o   (trial_o),
    .busy_o    (busy_o),
    .valid_o   (valid_o),
    .invalid_o (invalid_o)
);

// File: tb/sar_seq_tb.sv
module sar_seq_tb;

    localparam int W     = 16;
    localparam int LIMIT = 40;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         conv_i = 1'b0;
    logic         cmp_i;
    logic [W-1:0] trial_o;
    logic         busy_o;
    logic [W-1:0] result_o;
    logic         valid_o;
    logic         invalid_o;

    logic [W-1:0] aval = '0;   // sampled analog level, offset binary

    typedef struct {
        logic [W-1:0] res;
        logic         inv;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   first_b = 1'b1;
    int   prev_gap = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    // ideal comparator
    assign cmp_i = (trial_o <= aval);

    sar_seq #(.W(W), .IDLE_LIMIT(LIMIT)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .conv_i    (conv_i),
        .cmp_i     (cmp_i),
        .trial_o   (trial_o),
        .busy_o    (busy_o),
        .result_o  (result_o),
        .valid_o   (valid_o),
        .invalid_o (invalid_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (!rst && valid_o) begin
            if (q.size() == 0) begin
                check(1'b0, "R5 unexpected result", 32'(result_o), 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(result_o == e.res, "R4 result", 32'(result_o), 32'(e.res));
                check(invalid_o == e.inv, "R6/R7 invalid qualifier", 32'(invalid_o), 32'(e.inv));
            end
        end
    end

    // driver: start at the next posedge, conv high for hold cycles,
    // optional retrigger during busy, next start gap cycles later
    task automatic convert(input logic signed [W-1:0] sval, input int gap,
                           input int hold, input bit retrig);
        exp_t e;
        e.res = sval;
        e.inv = first_b || (prev_gap > LIMIT);
        q.push_back(e);
        first_b  = 1'b0;
        prev_gap = gap;
        aval   = sval ^ 16'h8000;
        conv_i = 1'b1;
        for (int i = 1; i <= gap; i++) begin
            @(negedge clk);
            if (i == hold) conv_i = 1'b0;
            if (retrig && i == 6) conv_i = 1'b1;
            if (retrig && i == 7) conv_i = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R8: reset state
        check(busy_o == 1'b0, "R8 busy in reset", 32'(busy_o), 0);
        check(valid_o == 1'b0, "R8 valid in reset", 32'(valid_o), 0);
        check(trial_o == '0, "R8 trial in reset", 32'(trial_o), 0);
        rst = 1'b0;
        @(negedge clk);

        // R1/R2: first trial and second trial for input 0x1234 (offset 0x9234)
        begin
            exp_t e;
            e.res = 16'h1234; e.inv = 1'b1;   // R6 first after reset
            q.push_back(e);
            first_b = 1'b0; prev_gap = 20;
            aval = 16'h9234;
            conv_i = 1'b1;
            @(negedge clk);
            check(busy_o && trial_o == 16'h8000, "R1 first trial", 32'(trial_o), 32'h8000);
            @(negedge clk);
            check(trial_o == 16'hC000, "R2 second trial", 32'(trial_o), 32'hC000);
            conv_i = 1'b0;
            repeat (18) @(negedge clk);
        end

        convert(16'sh8000, 20, 1, 1'b0);   // R4 negative full scale
        convert(16'sh7FFF, 40, 2, 1'b0);   // R4 positive full scale
        convert(16'sh0000, 41, 1, 1'b0);   // R7 gap exactly limit: valid; midscale
        convert(-16'sd1,   20, 1, 1'b0);   // R7 gap over limit: invalid
        convert(16'sh5A5A, 30, 25, 1'b0);  // R9 held high past completion
        convert(16'sh0001, 25, 1, 1'b1);   // R5 retrigger during busy
        convert(-16'sd12345, 20, 1, 1'b0);

        // R8: reset in mid conversion aborts and re-arms the first-result rule
        aval = 16'h0000;
        conv_i = 1'b1;
        repeat (5) @(negedge clk);
        conv_i = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(busy_o == 1'b0, "R8 abort busy", 32'(busy_o), 0);
        check(trial_o == '0, "R8 abort trial", 32'(trial_o), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        check(q.size() == 0, "R8 no result after abort", 32'(q.size()), 0);
        first_b = 1'b1;

        convert(16'sh4000, 20, 1, 1'b0);   // R6 first after reset: invalid
        convert(16'sh2AAA, 20, 1, 1'b0);

        repeat (5) @(negedge clk);
        check(q.size() == 0, "R3 all results delivered", 32'(q.size()), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule